// File: doc/BRIEF.md
# Multi-Channel Serial DAC Controller

This block drives seven 8-bit control values into two four-channel 8-bit serial converters. Each converter has four interface lines: a serial clock, a serial data line, a per-converter load strobe and a per-converter latch strobe that updates all outputs at once. A pulse on `frame_done` tells the block that a complete frame is present on `frame_vals`. The block copies all seven values into its own registers in that cycle. From then on the frame buffer may change without affecting the transfer.

The controller makes its serial clock by dividing the system clock. The clock runs only while a transfer is in progress. For each channel, in ascending order, it shifts out an 11-bit word and then pulses that converter's load line. Channels 0 to 3 belong to converter 0 and channels 4 to 6 to converter 1. When the last channel of a converter has been loaded, the controller pulses that converter's latch line. `busy` marks the whole sequence. The converter samples data on the falling clock edge, so the controller changes data only on rising edges.

Top module: `mcdac_ctrl`

## Requirements
- R1: `busy` rises in the cycle after a `frame_done` pulse seen while idle. It stays high through every load and latch pulse and falls on the same clock edge at which the last latch pulse of converter 1 ends.
- R2: Each serial word is 11 bits, sent MSB first, as `{addr[1:0], range, value[7:0]}`. `addr` is the channel number modulo 4, `range` is the parameter `RNG_BIT` (default 1), and `value` is the captured byte for that channel. Channel c occupies `frame_vals[8c+7:8c]`.
- R3: `dac_sdo` changes only on the system clock edge at which `dac_sclk` rises. It therefore stays stable across every falling edge of `dac_sclk`.
- R4: While `busy` is high, `dac_sclk` has a period of 2*HALF system clocks (20 ns with the defaults). While `busy` is low, `dac_sclk` is low and all load and latch lines are high.
- R5: Channels are sent in the order 0 to 6. Channels 0 to 3 use `dac_load_n[0]` and channels 4 to 6 use `dac_load_n[1]`. Every channel is loaded exactly once per frame.
- R6: After the 11th bit of a word, that converter's load line goes low for exactly one `dac_sclk` period. No two load lines are ever low together.
- R7: After the last channel of a converter has been loaded, its latch line goes low exactly once, for exactly one `dac_sclk` period. That latch pulse comes after that converter's final load pulse. A latch line is never low while any load line is low. A frame has two latch pulses.
- R8: The values are captured at the `frame_done` that starts a frame. Changes on `frame_vals` during `busy` have no effect on the words sent.
- R9: A `frame_done` pulse while `busy` is high is ignored. It neither restarts nor queues a second transfer.
- R10: During and just after reset, `busy` is 0, `dac_sclk` is 0, `dac_sdo` is 0 and all load and latch lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle pulse: a full frame is present on `frame_vals` |
| frame_vals | input | 56 | Seven control bytes, channel c at bits 8c+7:8c |
| busy | output | 1 | High while a transfer is in progress |
| dac_sclk | output | 1 | Serial clock to both converters |
| dac_sdo | output | 1 | Serial data to both converters |
| dac_load_n | output | 2 | Active-low load strobe, one per converter |
| dac_latch_n | output | 2 | Active-low output-update strobe, one per converter |

## Verification
The main transfer is exercised with four patterns:
- Ascending bytes show whether channels are swapped or misordered.
- All-ones against all-zeros, and a walking-bit pattern, show whether the bits are in the wrong order or dropped, or whether the range bit is missing.
- A frame whose buffer is overwritten and re-triggered while the transfer runs shows whether the values are captured once and whether a trigger during `busy` is ignored.

Every word decoded at the pins is compared against a queue of expected (converter, word) pairs. The widths of the load and latch pulses and the serial clock period are timed against the system clock.

// File: rtl/mcdac_pkg.sv
package mcdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_SHIFT = 3'd2,
    ST_LOAD  = 3'd3,
    ST_LATCH = 3'd4
  } mcdac_st_e;

endpackage

// File: rtl/mcdac_rst_sync.sv
module mcdac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mcdac_clkgen.sv
module mcdac_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic halt,
  output logic sclk,
  output logic rise_tick
);

  localparam int CNTW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNTW-1:0] CNT_TOP = CNTW'(HALF - 1);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            sclk_q, sclk_d;
  logic            wrap;

  assign wrap = (cnt_q == CNT_TOP);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = halt ? 1'b0 : ~sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk      = sclk_q;
  assign rise_tick = run && wrap && !sclk_q;

endmodule

// File: rtl/mcdac_store.sv
module mcdac_store #(
  parameter int NCH = 7,
  parameter int DW  = 8,
  parameter int CW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [NCH*DW-1:0] vals_in,
  input  logic [CW-1:0]     sel,
  output logic [DW-1:0]     val_out
);

  logic [NCH-1:0][DW-1:0] held;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (cap) val_q <= vals_in[g*DW +: DW];
    end
    assign held[g] = val_q;
  end

  always_comb begin
    val_out = '0;
    for (int i = 0; i < NCH; i++) begin
      if (int'(sel) == i) val_out = held[i];
    end
  end

endmodule

// File: rtl/mcdac_engine.sv
module mcdac_engine
  import mcdac_pkg::*;
#(
  parameter int NCH     = 7,
  parameter int CPD     = 4,
  parameter int DW      = 8,
  parameter bit RNG_BIT = 1'b1,
  parameter int NDEV    = 2,
  parameter int CW      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_done,
  input  logic            tick,
  input  logic [DW-1:0]   val,
  output logic [CW-1:0]   sel,
  output logic            cap,
  output logic            busy,
  output logic            halt,
  output logic            sdo,
  output logic [NDEV-1:0] load_n,
  output logic [NDEV-1:0] latch_n
);

  localparam int AW   = (CPD > 1) ? $clog2(CPD) : 1;
  localparam int WW   = AW + 1 + DW;
  localparam int BW   = $clog2(WW);
  localparam int DVW  = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam logic [CW-1:0] CH_LAST  = CW'(NCH - 1);
  localparam logic [BW-1:0] BIT_FIRST = BW'(WW - 1);

  mcdac_st_e       st_q, st_d;
  logic [CW-1:0]   ch_q, ch_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic            sdo_q, sdo_d;
  logic [NDEV-1:0] load_q, load_d;
  logic [NDEV-1:0] latch_q, latch_d;
  logic            busy_q, busy_d;

  logic [DVW-1:0]  dev_cur;
  logic            last_cur;
  logic [AW-1:0]   addr_d;
  logic [WW-1:0]   word_d;

  // converter index and end-of-converter flag for the channel in progress
  assign dev_cur  = DVW'(int'(ch_q) / CPD);
  assign last_cur = ((int'(ch_q) % CPD) == (CPD - 1)) || (ch_q == CH_LAST);

  // word of the channel selected for the next cycle
  assign addr_d = AW'(int'(ch_d) % CPD);
  assign word_d = {addr_d, RNG_BIT, val};

  always_comb begin
    st_d    = st_q;
    ch_d    = ch_q;
    bit_d   = bit_q;
    sdo_d   = sdo_q;
    load_d  = load_q;
    latch_d = latch_q;
    busy_d  = busy_q;
    cap     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (frame_done) begin
          st_d   = ST_START;
          ch_d   = '0;
          busy_d = 1'b1;
          cap    = 1'b1;
        end
      end
      ST_START: begin
        if (tick) begin
          st_d  = ST_SHIFT;
          bit_d = BIT_FIRST;
          sdo_d = word_d[WW-1];
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (bit_q == '0) begin
            st_d            = ST_LOAD;
            sdo_d           = 1'b0;
            load_d[dev_cur] = 1'b0;
          end else begin
            bit_d = bit_q - 1'b1;
            sdo_d = word_d[bit_q - 1'b1];
          end
        end
      end
      ST_LOAD: begin
        if (tick) begin
          load_d = '1;
          if (last_cur) begin
            st_d             = ST_LATCH;
            latch_d[dev_cur] = 1'b0;
          end else begin
            ch_d  = ch_q + 1'b1;
            st_d  = ST_SHIFT;
            bit_d = BIT_FIRST;
            sdo_d = word_d[WW-1];
          end
        end
      end
      ST_LATCH: begin
        if (tick) begin
          latch_d = '1;
          if (ch_q == CH_LAST) begin
            st_d   = ST_IDLE;
            busy_d = 1'b0;
          end else begin
            ch_d  = ch_q + 1'b1;
            st_d  = ST_SHIFT;
            bit_d = BIT_FIRST;
            sdo_d = word_d[WW-1];
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ch_q    <= '0;
      bit_q   <= '0;
      sdo_q   <= 1'b0;
      load_q  <= '1;
      latch_q <= '1;
      busy_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ch_q    <= ch_d;
      bit_q   <= bit_d;
      sdo_q   <= sdo_d;
      load_q  <= load_d;
      latch_q <= latch_d;
      busy_q  <= busy_d;
    end
  end

  assign sel     = ch_d;
  assign busy    = busy_q;
  assign halt    = (st_q == ST_LATCH) && (ch_q == CH_LAST);
  assign sdo     = sdo_q;
  assign load_n  = load_q;
  assign latch_n = latch_q;

endmodule

// File: rtl/mcdac_ctrl.sv
module mcdac_ctrl #(
  parameter int NCH     = 7,
  parameter int CPD     = 4,
  parameter int DW      = 8,
  parameter int HALF    = 2,
  parameter bit RNG_BIT = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_done,
  input  logic [NCH*DW-1:0]            frame_vals,
  output logic                         busy,
  output logic                         dac_sclk,
  output logic                         dac_sdo,
  output logic [(NCH+CPD-1)/CPD-1:0]   dac_load_n,
  output logic [(NCH+CPD-1)/CPD-1:0]   dac_latch_n
);

  localparam int NDEV = (NCH + CPD - 1) / CPD;
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1;

  logic          rst_core_n;
  logic          tick;
  logic          halt;
  logic          cap;
  logic [CW-1:0] sel;
  logic [DW-1:0] val;

  mcdac_rst_sync u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  mcdac_clkgen #(.HALF(HALF)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (busy),
    .halt      (halt),
    .sclk      (dac_sclk),
    .rise_tick (tick)
  );

  mcdac_store #(.NCH(NCH), .DW(DW), .CW(CW)) u_store (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cap     (cap),
    .vals_in (frame_vals),
    .sel     (sel),
    .val_out (val)
  );

  mcdac_engine #(
    .NCH(NCH), .CPD(CPD), .DW(DW), .RNG_BIT(RNG_BIT), .NDEV(NDEV), .CW(CW)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .frame_done (frame_done),
    .tick       (tick),
    .val        (val),
    .sel        (sel),
    .cap        (cap),
    .busy       (busy),
    .halt       (halt),
    .sdo        (dac_sdo),
    .load_n     (dac_load_n),
    .latch_n    (dac_latch_n)
  );

endmodule

// File: rtl/mcdac_ctrl_chk.sv
module mcdac_ctrl_chk #(
  parameter int NDEV = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_done,
  input logic            busy,
  input logic            sclk,
  input logic            sdo,
  input logic [NDEV-1:0] load_n,
  input logic [NDEV-1:0] latch_n
);

  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && frame_done) |=> busy);

  p_strobe_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&latch_n) || !(&load_n)) |-> busy);

  p_sdo_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $rose(sclk));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && (&load_n) && (&latch_n)));

  p_one_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~load_n));

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!(&load_n) && !(&latch_n)));

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    p_load_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(load_n[i]) |=> !load_n[i]);
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latch_n[i]) |=> !latch_n[i]);
  end

endmodule

bind mcdac_ctrl mcdac_ctrl_chk #(.NDEV(NDEV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .frame_done (frame_done),
  .busy       (busy),
  .sclk       (dac_sclk),
  .sdo        (dac_sdo),
  .load_n     (dac_load_n),
  .latch_n    (dac_latch_n)
);

// File: tb/mcdac_ctrl_bench.sv
`timescale 1ns/1ps
module mcdac_ctrl_bench;

  localparam int NCH  = 7;
  localparam int CPD  = 4;
  localparam int DW   = 8;
  localparam int HALF = 2;
  localparam realtime TCLK = 5.0;
  localparam realtime PER  = 2.0 * HALF * TCLK;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_done;
  logic [NCH*DW-1:0] frame_vals;
  logic              busy, dac_sclk, dac_sdo;
  logic [1:0]        dac_load_n, dac_latch_n;

  always #(TCLK/2) clk = ~clk;

  mcdac_ctrl u_mcdac_ctrl (
    .clk (clk), .rst_n (rst_n), .frame_done (frame_done), .frame_vals (frame_vals),
    .busy (busy), .dac_sclk (dac_sclk), .dac_sdo (dac_sdo),
    .dac_load_n (dac_load_n), .dac_latch_n (dac_latch_n)
  );

  int vectors = 0;
  int errors  = 0;
  logic [11:0] exp_q[$];

  logic [10:0] sh;
  int          nbits;
  int          loads_since[2];
  int          load_cnt, latch_cnt;
  realtime     t_load[2], t_latch[2], last_rise;
  logic        sdo_prev, sclk_prev;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: serial shift, pins sampled on falling sclk outside strobe slots
  always @(negedge dac_sclk) begin
    if (rst_n && (&dac_load_n) && (&dac_latch_n)) begin
      sh = {sh[9:0], dac_sdo};
      nbits++;
    end
  end

  // R3: data may only move together with a rising sclk
  always @(negedge clk) begin
    if (rst_n && (dac_sdo !== sdo_prev))
      check(dac_sclk && !sclk_prev, "R3 sdo changed off a rising sclk", dac_sclk, 1);
    sdo_prev  = dac_sdo;
    sclk_prev = dac_sclk;
  end

  always @(posedge dac_sclk) begin
    if (last_rise >= 0.0)
      check(($realtime - last_rise) == PER, "R4 sclk period ps",
            longint'(($realtime - last_rise) * 1000), longint'(PER * 1000));
    last_rise = $realtime;
  end

  task automatic on_load_fall(input int d);
    logic [11:0] got, exp;
    check(nbits == 11, "R2 bits before load", nbits, 11);
    check(busy == 1'b1, "R1 busy during load", busy, 1);
    got = {d[0], sh};
    if (exp_q.size() == 0) check(1'b0, "R5 unexpected load", got, 0);
    else begin
      exp = exp_q.pop_front();
      check(got == exp, "R2 R5 device and word", got, exp);
    end
    nbits = 0;
    loads_since[d]++;
    load_cnt++;
    t_load[d] = $realtime;
  endtask

  task automatic on_load_rise(input int d);
    if (t_load[d] >= 0.0)
      check(($realtime - t_load[d]) == PER, "R6 load width ps",
            longint'(($realtime - t_load[d]) * 1000), longint'(PER * 1000));
  endtask

  task automatic on_latch_fall(input int d);
    int want;
    want = (d == 0) ? 4 : 3;
    check(loads_since[d] == want, "R7 loads before latch", loads_since[d], want);
    check(busy == 1'b1, "R1 busy during latch", busy, 1);
    loads_since[d] = 0;
    latch_cnt++;
    t_latch[d] = $realtime;
  endtask

  task automatic on_latch_rise(input int d);
    if (t_latch[d] >= 0.0)
      check(($realtime - t_latch[d]) == PER, "R7 latch width ps",
            longint'(($realtime - t_latch[d]) * 1000), longint'(PER * 1000));
  endtask

  always @(negedge dac_load_n[0])  if (rst_n) on_load_fall(0);
  always @(negedge dac_load_n[1])  if (rst_n) on_load_fall(1);
  always @(posedge dac_load_n[0])  if (rst_n) on_load_rise(0);
  always @(posedge dac_load_n[1])  if (rst_n) on_load_rise(1);
  always @(negedge dac_latch_n[0]) if (rst_n) on_latch_fall(0);
  always @(negedge dac_latch_n[1]) if (rst_n) on_latch_fall(1);
  always @(posedge dac_latch_n[0]) if (rst_n) on_latch_rise(0);
  always @(posedge dac_latch_n[1]) if (rst_n) on_latch_rise(1);

  // driver: queue the expected words, then start a frame
  task automatic run_frame(input logic [NCH*DW-1:0] v, input bit disturb);
    for (int c = 0; c < NCH; c++)
      exp_q.push_back({1'(c / CPD), 2'(c % CPD), 1'b1, v[c*DW +: DW]});
    nbits = 0; last_rise = -1.0; load_cnt = 0; latch_cnt = 0;
    loads_since[0] = 0; loads_since[1] = 0;
    t_load[0] = -1.0; t_load[1] = -1.0; t_latch[0] = -1.0; t_latch[1] = -1.0;
    @(negedge clk);
    frame_vals = v;
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    check(busy == 1'b1, "R1 busy after frame_done", busy, 1);
    if (disturb) begin
      repeat (30) @(negedge clk);
      frame_vals = ~v;   // R8: must not reach the pins
      frame_done = 1'b1; // R9: must be ignored
      @(negedge clk);
      frame_done = 1'b0;
      check(busy == 1'b1, "R9 busy kept on retrigger", busy, 1);
    end
    @(negedge busy);
    #1;
    check(latch_cnt == 2, "R7 latch pulses per frame", latch_cnt, 2);
    check(exp_q.size() == 0, "R5 all channels loaded", exp_q.size(), 0);
    check((&dac_load_n) && (&dac_latch_n) && !dac_sclk, "R4 idle lines at busy fall",
          {dac_sclk, dac_load_n, dac_latch_n}, 5'b01111);
    repeat (40) @(negedge clk);
    check(busy == 1'b0, "R9 no second transfer", busy, 0);
    check(load_cnt == NCH, "R9 loads per frame", load_cnt, NCH);
    check(!dac_sclk, "R4 sclk low when idle", dac_sclk, 0);
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    #(TCLK * 100000);
    check(1'b0, "R1 watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    logic [NCH*DW-1:0] v;
    rst_n = 1'b0; frame_done = 1'b0; frame_vals = '0;
    sh = '0; nbits = 0; last_rise = -1.0; sdo_prev = 1'b0; sclk_prev = 1'b0;
    t_load[0] = -1.0; t_load[1] = -1.0; t_latch[0] = -1.0; t_latch[1] = -1.0;
    loads_since[0] = 0; loads_since[1] = 0; load_cnt = 0; latch_cnt = 0;
    repeat (3) @(negedge clk);
    check({busy, dac_sclk, dac_sdo, dac_load_n, dac_latch_n} == 7'b0001111,
          "R10 outputs in reset", {busy, dac_sclk, dac_sdo, dac_load_n, dac_latch_n}, 7'b0001111);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, dac_sclk, dac_sdo, dac_load_n, dac_latch_n} == 7'b0001111,
          "R10 outputs after reset", {busy, dac_sclk, dac_sdo, dac_load_n, dac_latch_n}, 7'b0001111);

    for (int c = 0; c < NCH; c++) v[c*DW +: DW] = 8'(8'h11 * (c + 1));
    run_frame(v, 1'b0);
    for (int c = 0; c < NCH; c++) v[c*DW +: DW] = (c % 2 == 0) ? 8'hFF : 8'h00;
    run_frame(v, 1'b0);
    for (int c = 0; c < NCH; c++) v[c*DW +: DW] = 8'(8'h01 << c);
    run_frame(v, 1'b0);
    v = 56'hA5_3C_80_01_7E_C3_5A;
    run_frame(v, 1'b1);

    report();
    $finish;
  end

endmodule